// File: doc/BRIEF.md
# Serial Peripheral Interface Master Port

This block is a register-programmed SPI master. Software reaches it through a small 32-bit word bus. Three control words set up the serial engine. A status word reports FIFO fill levels and activity. A single data word feeds a 16-entry transmit queue when written and drains a 16-entry receive queue when read. Two read-only words report a fixed revision number and the build-time capacities.

The serial engine produces SCLK from the system clock through a programmable divider. It handles all four clock polarity and phase combinations, frames of 1 to 32 bits, and either bit order. It can route its own output back into its input for self-test. Transmit and receive are enabled independently. When receive is on but no transmit word is waiting, the engine keeps clocking frames that send zeros, and it stops only when the receive queue is full. Chip selects are not timed by the engine: a control bit sets the level of whichever of the four select lines is chosen, and the other lines stay high.

Top module: `spi_host_port`

## Requirements
- R1: After reset, control0 and control1 read 0, control2 reads 0x200, status reads 0x2, all four chip-select lines are high, and SCLK and MOSI are low.
- R2: The revision word (byte offset 0x60) reads 0x00011900. The capacity word (0x64) reads 0x040F0F1F, which encodes bits 7:0 = width-1, 15:8 = receive depth-1, 23:16 = transmit depth-1 and bit 26 = SPI capable. The words at 0x10 and 0x14 read 0. Control0 (0x00) keeps only the bits in 0x70CF, control1 (0x04) only the bits in 0x1FFFFF, and control2 (0x08) only the bits in 0xFCF.
- R3: A write to the data word (0x18) appends to the transmit queue and is dropped when 16 entries are already held. A read pops the receive queue in arrival order, and a read of an empty queue returns 0.
- R4: The status word (0x0C) holds receive-full in bit 0, transmit-not-full in bit 1, busy in bit 2, the receive count in bits 8:4 and the transmit count in bits 16:12. All other bits are 0.
- R5: With control1 bits 15:0 = D and bits 20:16 = N-1, a frame toggles SCLK 2N times, each level lasting D+1 clock cycles. Between frames SCLK rests at the polarity bit (control0 bit 1).
- R6: With the phase bit (control0 bit 0) clear, data is sampled on the first edge of each bit and changed on the second. With the phase bit set, data is changed on the first edge and sampled on the second. Data exchanged with an external device is correct in all four modes.
- R7: Control0 bit 6 selects LSB-first order, otherwise MSB-first. Only the low N bits of a transmit word are sent, and received words are zero-extended.
- R8: With control0 bit 7 set, the receiver takes the transmitted bit in place of MISO, so each received word equals the low N bits of the sent word.
- R9: With receive enabled (control2 bit 7) and transmit disabled (bit 8 clear), frames that send zeros run while control2 bit 0 is set and the receive queue has room. They stop at 16 entries and resume after a pop, and the transmit queue is left untouched.
- R10: With transmit enabled and receive disabled, frames run until the transmit queue is empty, and received bits are discarded.
- R11: MOSI stays low unless control2 bit 1 is set.
- R12: Chip-select line k equals control2 bit 9 when control2 bits 11:10 equal k, and is high otherwise.
- R13: Control2 bit 3 empties the transmit queue, bit 2 empties the receive queue, and bit 6 empties both and aborts a frame. Each of these bits reads back as 0 one cycle later, and the other control bits are preserved.
- R14: Busy is set while a frame runs, including the cycle in which its word is written into the receive queue, and also while transmit is enabled with words queued. The enable bit does not gate this second condition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 7 | Byte address of the register word |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read (pops the receive queue at 0x18) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_line | output | 4 | Chip-select lines, level set by software |

## Verification
The assertions assume that software leaves the chip-select field alone while a frame is in flight and changes the polarity bit only while the engine is idle. The bench changes control0, control1 and the select field only after it has seen the busy bit low. It stops a free-running receive stream by clearing the enable bit alone, leaving the other control2 bits as they were. Its device model follows the programmed mode and bit order, and it drives MISO only in response to SCLK edges.

// File: rtl/spi_host_port.sv
`timescale 1ns/1ps
module spi_host_port #(
  parameter int          DEPTH    = 16,
  parameter int          CS_LINES = 4,
  parameter logic [31:0] REV_ID   = 32'h0001_1900
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [6:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic [3:0]  cs_line
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [31:0] M0 = 32'h0000_70CF;
  localparam logic [31:0] M1 = 32'h001F_FFFF;
  localparam logic [31:0] M2 = 32'h0000_0FCF;
  localparam logic [31:0] CLR_BITS = 32'h0000_004C;
  localparam logic [31:0] FEAT = {5'd0, 1'b1, 2'd0, 8'(DEPTH-1), 8'(DEPTH-1), 8'd31};

  logic [31:0] ctl0, ctl1, ctl2;

  wire aligned = bus_addr[1:0] == 2'b00;
  wire [4:0] widx = bus_addr[6:2];
  wire wr_c0  = bus_wr && aligned && widx == 5'd0;
  wire wr_c1  = bus_wr && aligned && widx == 5'd1;
  wire wr_c2  = bus_wr && aligned && widx == 5'd2;
  wire wr_dat = bus_wr && aligned && widx == 5'd6;
  wire rd_dat = bus_rd && aligned && widx == 5'd6;

  wire        cpha   = ctl0[0];
  wire        cpol   = ctl0[1];
  wire        lsb    = ctl0[6];
  wire        loop   = ctl0[7];
  wire [15:0] div_m1 = ctl1[15:0];
  wire [4:0]  len_m1 = ctl1[20:16];
  wire        en     = ctl2[0];
  wire        txdoe  = ctl2[1];
  wire        rxclr  = ctl2[2];
  wire        txclr  = ctl2[3];
  wire        srst   = ctl2[6];
  wire        rxen   = ctl2[7];
  wire        txen   = ctl2[8];
  wire        cslvl  = ctl2[9];
  wire [1:0]  cssel  = ctl2[11:10];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl0 <= '0;
      ctl1 <= '0;
      ctl2 <= 32'h0000_0200;
    end else begin
      if (wr_c0) ctl0 <= bus_wdata & M0;
      if (wr_c1) ctl1 <= bus_wdata & M1;
      if (wr_c2) ctl2 <= bus_wdata & M2;
      else       ctl2 <= ctl2 & ~CLR_BITS;
    end
  end

  // transmit queue
  logic [31:0]   tx_mem [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp;
  logic [CW-1:0] tx_cnt;
  wire tx_empty = tx_cnt == '0;
  wire tx_full  = tx_cnt == FULL;

  // receive queue
  logic [31:0]   rx_mem [DEPTH];
  logic [AW-1:0] rx_wp, rx_rp;
  logic [CW-1:0] rx_cnt;
  wire rx_empty = rx_cnt == '0;
  wire rx_full  = rx_cnt == FULL;

  // serial engine state
  logic        run;
  logic [15:0] hcnt;
  logic [5:0]  half;
  logic [31:0] tsh, rsh;
  logic        sclk_q;

  wire blocked  = txclr | rxclr | srst;
  wire start    = !run && en && !blocked && (rxen ? !rx_full : (txen && !tx_empty));
  wire half_end = run && hcnt == div_m1;
  wire last     = half == {len_m1, 1'b1};
  wire fin      = half_end && last;
  wire tbit     = lsb ? tsh[0] : tsh[len_m1];
  wire din      = loop ? tbit : miso;

  wire tx_push = wr_dat && !tx_full;
  wire tx_pop  = start && txen && !tx_empty;
  wire rx_push = fin && rxen && !rx_full;
  wire rx_pop  = rd_dat && !rx_empty;

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= bus_wdata;
    if (rx_push) rx_mem[rx_wp] <= rsh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else if (txclr || srst) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (tx_pop)  tx_rp <= tx_rp + 1'b1;
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else if (rxclr || srst) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (rx_push) rx_wp <= rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= rx_rp + 1'b1;
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
    end
  end

  // a frame is 2N halves; entering an odd half samples, entering an even half shifts
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; hcnt <= '0; half <= '0;
      tsh <= '0; rsh <= '0; sclk_q <= 1'b0;
    end else if (srst) begin
      run <= 1'b0; hcnt <= '0; half <= '0;
      sclk_q <= cpol;
    end else if (start) begin
      run    <= 1'b1;
      hcnt   <= '0;
      half   <= '0;
      tsh    <= (txen && !tx_empty) ? tx_mem[tx_rp] : '0;
      rsh    <= '0;
      sclk_q <= cpol ^ cpha;
    end else if (run) begin
      if (half_end) begin
        hcnt <= '0;
        if (last) begin
          run    <= 1'b0;
          sclk_q <= cpol;
        end else begin
          half   <= half + 1'b1;
          sclk_q <= cpol ^ cpha ^ ~half[0];
          if (!half[0])
            rsh <= lsb ? ((rsh >> 1) | ({31'd0, din} << len_m1)) : {rsh[30:0], din};
          else
            tsh <= lsb ? (tsh >> 1) : (tsh << 1);
        end
      end else begin
        hcnt <= hcnt + 1'b1;
      end
    end else begin
      sclk_q <= cpol;
    end
  end

  wire busy = run | (txen & !tx_empty);

  assign sclk = sclk_q;
  assign mosi = txdoe && run && tbit;

  for (genvar i = 0; i < 4; i++) begin : g_cs
    if (i < CS_LINES) begin : g_on
      assign cs_line[i] = (cssel == 2'(i)) ? cslvl : 1'b1;
    end else begin : g_off
      assign cs_line[i] = 1'b1;
    end
  end

  logic [31:0] stat;
  always_comb begin
    stat = '0;
    stat[0] = rx_full;
    stat[1] = !tx_full;
    stat[2] = busy;
    stat[4 +: CW]  = rx_cnt;
    stat[12 +: CW] = tx_cnt;
  end

  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      case (widx)
        5'd0:    bus_rdata = ctl0;
        5'd1:    bus_rdata = ctl1;
        5'd2:    bus_rdata = ctl2;
        5'd3:    bus_rdata = stat;
        5'd6:    bus_rdata = rx_empty ? 32'd0 : rx_mem[rx_rp];
        5'd24:   bus_rdata = REV_ID;
        5'd25:   bus_rdata = FEAT;
        default: bus_rdata = '0;
      endcase
    end
  end

  assert_tx_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= FULL);

  assert_rx_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= FULL);

  assert_frame_push_R14: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && rxen && !rxclr && !srst && !rx_pop && !rx_full) |=> rx_cnt == $past(rx_cnt) + 1'b1);

  assert_self_clear_R13: assert property (@(posedge clk) disable iff (!rst_n)
    ((ctl2 & CLR_BITS) != 0 && !wr_c2) |=> (ctl2 & CLR_BITS) == 0);

  assert_sclk_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !$past(run) && cpol == $past(cpol)) |-> sclk == cpol);

  assert_cs_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> $stable(cs_line));
endmodule

// File: tb/spi_host_port_tb.sv
`timescale 1ns/1ps
module spi_host_port_tb_top;
  localparam logic [6:0] A_C0 = 7'h00, A_C1 = 7'h04, A_C2 = 7'h08, A_ST = 7'h0C,
                         A_IC = 7'h10, A_IS = 7'h14, A_DT = 7'h18, A_RV = 7'h60, A_FT = 7'h64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [6:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] wdata = '0;
  wire  [31:0] rdata;
  wire         sclk, mosi;
  logic        miso;
  wire  [3:0]  cs;

  spi_host_port dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_rd(rd),
    .bus_wdata(wdata), .bus_rdata(rdata), .sclk(sclk), .mosi(mosi),
    .miso(miso), .cs_line(cs)
  );

  int n_cmp = 0, n_bad = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wreg(logic [6:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rreg(logic [6:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    do rreg(A_ST, s); while (s[2]);
  endtask

  task automatic wait_rx();
    logic [31:0] s;
    do rreg(A_ST, s); while (s[8:4] == 5'd0);
  endtask

  function automatic logic [31:0] lowmask(int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
  endfunction

  // external device model
  logic        s_cpol = 1'b0, s_cpha = 1'b0, s_lsb = 1'b0;
  int          s_n = 0, s_idx = 0, s_smp = 0;
  logic [31:0] s_word = '0, s_got = '0;
  int          n_edges = 0, n_lead = 0;
  time         t_e0 = 0, t_e1 = 0;
  logic        mosi_seen = 1'b0;

  always @(sclk) begin
    if (n_edges == 0) t_e0 = $time;
    if (n_edges == 1) t_e1 = $time;
    n_edges++;
    if (sclk !== s_cpol) begin
      n_lead++;
      if (s_cpha) s_idx++;
      else if (s_smp < s_n) begin
        if (s_lsb) s_got[s_smp] = mosi; else s_got = {s_got[30:0], mosi};
        s_smp++;
      end
    end else begin
      if (!s_cpha) s_idx++;
      else if (s_smp < s_n) begin
        if (s_lsb) s_got[s_smp] = mosi; else s_got = {s_got[30:0], mosi};
        s_smp++;
      end
    end
  end

  always_comb begin
    if (s_idx >= 0 && s_idx < s_n) miso = s_word[s_lsb ? s_idx : (s_n - 1 - s_idx)];
    else miso = 1'b0;
  end

  always @(posedge clk) if (mosi) mosi_seen <= 1'b1;

  task automatic xfer(bit cpol, bit cpha, bit lsb, bit loop, int n, int div,
                      logic [31:0] word, logic [31:0] sw, output logic [31:0] got);
    wreg(A_C2, 32'h20C);
    wreg(A_C0, 32'h100C | (32'(loop) << 7) | (32'(lsb) << 6) | (32'(cpol) << 1) | 32'(cpha));
    wreg(A_C1, (32'(n - 1) << 16) | 32'(div));
    repeat (2) @(negedge clk);
    s_cpol = cpol; s_cpha = cpha; s_lsb = lsb; s_n = loop ? 0 : n;
    s_word = sw; s_idx = cpha ? -1 : 0; s_smp = 0; s_got = '0;
    wreg(A_DT, word);
    wreg(A_C2, 32'h183);
    wait_rx();
    wreg(A_C2, 32'h182);
    wait_idle();
    rreg(A_DT, got);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R14 watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v, got;
    int lens[6] = '{1, 5, 8, 16, 31, 32};
    int slens[2] = '{8, 13};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 cs", {28'd0, cs}, 32'hF);
    check("R1 sclk/mosi", {30'd0, sclk, mosi}, 32'h0);
    rreg(A_C0, v); check("R1 ctl0", v, 32'h0);
    rreg(A_C1, v); check("R1 ctl1", v, 32'h0);
    rreg(A_C2, v); check("R1 ctl2", v, 32'h200);
    rreg(A_ST, v); check("R1 status", v, 32'h2);

    // R2 fixed words and write masks
    rreg(A_RV, v); check("R2 revision", v, 32'h0001_1900);
    rreg(A_FT, v); check("R2 feature", v, 32'h040F_0F1F);
    rreg(A_IC, v); check("R2 int ctl", v, 32'h0);
    rreg(A_IS, v); check("R2 int st", v, 32'h0);
    wreg(A_C0, 32'hFFFF_FFFF); rreg(A_C0, v); check("R2 ctl0 mask", v, 32'h70CF);
    wreg(A_C1, 32'hFFFF_FFFF); rreg(A_C1, v); check("R2 ctl1 mask", v, 32'h1F_FFFF);
    wreg(A_C0, 32'h0); wreg(A_C1, 32'h0);

    // R12 chip-select routing
    wreg(A_C2, 32'h800); @(negedge clk); check("R12 sel2 low", {28'd0, cs}, 32'hB);
    wreg(A_C2, 32'hE00); @(negedge clk); check("R12 sel3 high", {28'd0, cs}, 32'hF);
    wreg(A_C2, 32'h000); @(negedge clk); check("R12 sel0 low", {28'd0, cs}, 32'hE);
    wreg(A_C2, 32'h400); @(negedge clk); check("R12 sel1 low", {28'd0, cs}, 32'hD);

    // R3 / R4 queue order, overflow drop, status fields
    wreg(A_C2, 32'h20C);
    wreg(A_C0, 32'h108C);
    wreg(A_C1, 32'h0007_0000);
    for (int i = 0; i < 17; i++) wreg(A_DT, 32'(i * 17 + 3));
    rreg(A_ST, v); check("R4 tx full status", v, 32'h0001_0000);
    wreg(A_C2, 32'h183);
    repeat (600) @(negedge clk);
    wreg(A_C2, 32'h182);
    wait_idle();
    rreg(A_ST, v); check("R4 rx full status", v, 32'h0000_0103);
    for (int i = 0; i < 16; i++) begin
      rreg(A_DT, v); check("R3 order", v, 32'(i * 17 + 3) & 32'hFF);
    end
    rreg(A_DT, v); check("R3 empty read", v, 32'h0);
    rreg(A_ST, v); check("R4 empty status", v, 32'h2);

    // R8 / R7 loopback sweep over modes, order, length and divider
    begin
      int k = 0;
      for (int cp = 0; cp < 2; cp++)
        for (int ph = 0; ph < 2; ph++)
          for (int lb = 0; lb < 2; lb++)
            for (int li = 0; li < 6; li++)
              for (int dv = 0; dv < 3; dv += 2) begin
                logic [31:0] w;
                w = 32'hA5C3_96E1 ^ (32'(k) * 32'h1357_9BDF);
                k++;
                xfer(cp[0], ph[0], lb[0], 1'b1, lens[li], dv, w, 32'h0, got);
                check("R8 R7 loopback", got, w & lowmask(lens[li]));
              end
    end

    // R6 / R7 exchange with the device model in all four modes
    begin
      int k = 0;
      for (int md = 0; md < 4; md++)
        for (int lb = 0; lb < 2; lb++)
          for (int li = 0; li < 2; li++) begin
            logic [31:0] w, sw;
            w  = 32'h3C5A_F00F ^ (32'(k) * 32'h0F1E_2D3B);
            sw = 32'h6B1D_2E47 ^ (32'(k) * 32'h2468_ACE1);
            k++;
            xfer(md[1], md[0], lb[0], 1'b0, slens[li], 1, w, sw, got);
            check("R6 R7 received", got, sw & lowmask(slens[li]));
            check("R6 R7 sent", s_got, w & lowmask(slens[li]));
          end
    end

    // R5 / R10 transmit-only frame timing, receive discarded
    for (int dv = 0; dv < 4; dv += 3) begin
      wreg(A_C2, 32'h20C);
      wreg(A_C0, 32'h100E);
      wreg(A_C1, 32'h0004_0000 | 32'(dv));
      repeat (3) @(negedge clk);
      s_cpol = 1'b1; s_cpha = 1'b0; s_n = 0; n_edges = 0; n_lead = 0;
      wreg(A_DT, 32'h15);
      wreg(A_C2, 32'h301);
      wait_idle();
      check("R5 edge count", 32'(n_edges), 32'd10);
      check("R5 pulse count", 32'(n_lead), 32'd5);
      check("R5 half period", 32'((t_e1 - t_e0) / 20), 32'(dv + 1));
      check("R5 idle level", {31'd0, sclk}, 32'h1);
      rreg(A_ST, v); check("R10 rx discarded", v, 32'h2);
    end

    // R11 data output enable gating
    wreg(A_C2, 32'h20C);
    wreg(A_C0, 32'h100C);
    wreg(A_C1, 32'h0007_0000);
    repeat (2) @(negedge clk);
    mosi_seen = 1'b0;
    wreg(A_DT, 32'hFF);
    wreg(A_C2, 32'h301);
    wait_idle();
    check("R11 mosi held low", {31'd0, mosi_seen}, 32'h0);
    mosi_seen = 1'b0;
    wreg(A_DT, 32'hFF);
    wreg(A_C2, 32'h303);
    wait_idle();
    check("R11 mosi driven", {31'd0, mosi_seen}, 32'h1);

    // R9 receive-only stream, transmit queue untouched
    wreg(A_C2, 32'h20C);
    s_n = 0; s_idx = 0;
    wreg(A_DT, 32'hFF);
    mosi_seen = 1'b0;
    wreg(A_C2, 32'h283);
    repeat (700) @(negedge clk);
    rreg(A_ST, v); check("R9 stops at full", v, 32'h0000_1103);
    check("R9 zeros sent", {31'd0, mosi_seen}, 32'h0);
    rreg(A_DT, v); check("R9 zero word", v, 32'h0);
    repeat (100) @(negedge clk);
    rreg(A_ST, v); check("R9 resumes after pop", v[8:4], 32'd16);
    wreg(A_C2, 32'h282);
    wait_idle();

    // R13 clear bits and soft reset
    wreg(A_C2, 32'h200);
    wait_idle();
    rreg(A_ST, v); check("R13 before tx clear", v[16:12], 32'd1);
    wreg(A_DT, 32'h1); wreg(A_DT, 32'h2);
    rreg(A_ST, v); check("R13 tx count 3", v[16:12], 32'd3);
    wreg(A_C2, 32'h608);
    rreg(A_C2, v); check("R13 tx clear self-clears", v, 32'h600);
    rreg(A_ST, v); check("R13 tx emptied", v, 32'h0000_0103);
    wreg(A_C2, 32'h604);
    rreg(A_C2, v); check("R13 rx clear self-clears", v, 32'h600);
    rreg(A_ST, v); check("R13 rx emptied", v, 32'h2);
    wreg(A_DT, 32'h5);
    wreg(A_C2, 32'h281);
    repeat (60) @(negedge clk);
    wreg(A_C2, 32'h2C0);
    rreg(A_C2, v); check("R13 reset self-clears", v, 32'h280);
    rreg(A_ST, v); check("R13 reset empties", v, 32'h2);
    rreg(A_C0, v); check("R13 ctl0 kept", v, 32'h100C);
    wreg(A_C2, 32'h200);

    // R14 busy
    wreg(A_C1, 32'h001F_0003);
    wreg(A_DT, 32'h1234_5678);
    rreg(A_ST, v); check("R14 idle not busy", v[2], 32'd0);
    wreg(A_C2, 32'h300);
    rreg(A_ST, v); check("R14 busy queued no enable", v[2], 32'd1);
    wreg(A_C2, 32'h301);
    repeat (20) @(negedge clk);
    rreg(A_ST, v); check("R14 busy in frame", v[2], 32'd1);
    check("R14 queue popped", v[16:12], 32'd0);
    wait_idle();
    rreg(A_ST, v); check("R14 busy clear", v, 32'h2);

    summary();
    $finish;
  end
endmodule